// File: doc/BRIEF.md
# Processor Control Register File

This block keeps the control registers of a 16-bit processor core: the status word and its backup copy, the program counter and its backup, the repeat-loop registers, the modulo-addressing bounds and an instruction break address. The execution unit reaches the registers by a 4-bit index with a move-to (write) port and a move-from (read) port. A separate debug port reaches the same registers with the same packing and masking rules, so a debugger always sees and leaves consistent state.

The status word is not held as a plain 16-bit register. It is kept as twelve separate flag bits, packed into a word when read and unpacked when written. Writes to either status copy drop four reserved bit positions, and writes to the modulo bounds drop bit 0. A status write that sets the stack-select flag while the extended-mode flag is clear raises a one-cycle illegal-instruction pulse. The block also performs the register side of exception entry and return: in one clock it saves PC+1 and the status word, reduces the status word to its supervisor-mode bit and loads the PC with a vector, and on return it restores both copies.

Top module: `cpu_ctrl_regs`

## Requirements
- R1: After a synchronous active-high reset every control register and the status word read as 0x0000, and `ill_o` and `syscall_o` are low.
- R2: Index map: 0 status word, 1 backup status, 2 PC, 3 backup PC, 7 repeat count, 8 repeat start, 9 repeat end, 10 modulo start, 11 modulo end, 14 break address; unlisted indices hold 16 bits as written. Both read ports are combinational and show a write from the following cycle on. The status word packs flags at bit positions 15, 13, 12, 11, 10, 9, 8, 7 (extended mode), 6 (stack select), 3, 2 and 0; all other bits read zero.
- R3: A write to index 0 or index 1 stores the value with bits 14, 5, 4 and 1 cleared (AND with 0xBFCD).
- R4: A write to index 10 or 11 stores the value with bit 0 cleared; writes to every other index except 0 and 1 store all 16 bits.
- R5: A status-word write (move-to, debug or return) whose bit 6 is 1 and bit 7 is 0 drives `ill_o` high for exactly the next cycle; the value is still stored.
- R6: An event with `evt_kind`=0 (trap) and `trap_num` n in 0..14 loads PC with 0xFFC4+n, the backup PC with PC+1 (modulo 2^16), the backup status with the current status word, and clears every status bit except bit 15, all in one clock.
- R7: A trap with `trap_num`=15 changes no register and drives `syscall_o` high for exactly the next cycle.
- R8: `evt_kind` 1 vectors to 0xFFC2, 2 to 0xFFC3 and 3 to 0xFFD5, with the same save and status reduction as R6; `trap_num` is ignored.
- R9: A return request loads PC from the backup PC and writes the backup status into the status word through the masked write path, including the R5 check.
- R10: The debug port writes and reads with the same rules as move-to/move-from; when both write ports are active in one cycle the move-to write is kept and the debug write is dropped.
- R11: Priority is event over return over register writes: a write in the cycle of an event or return is dropped, and a return in the cycle of an event is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mt_en | input | 1 | Move-to write enable |
| mt_idx | input | 4 | Move-to register index |
| mt_data | input | 16 | Move-to write value |
| mf_idx | input | 4 | Move-from register index |
| mf_data | output | 16 | Move-from read value |
| dbg_wr | input | 1 | Debug write enable |
| dbg_idx | input | 4 | Debug read/write index |
| dbg_wdata | input | 16 | Debug write value |
| dbg_rdata | output | 16 | Debug read value |
| evt_req | input | 1 | Exception/trap entry request |
| evt_kind | input | 2 | 0 trap, 1 reserved instruction, 2 address error, 3 debug trap |
| trap_num | input | 4 | Trap number for `evt_kind`=0 |
| rte_req | input | 1 | Return-from-exception request |
| pc_o | output | 16 | Current PC |
| psw_o | output | 16 | Packed status word |
| ill_o | output | 1 | Illegal status combination pulse |
| syscall_o | output | 1 | System-call trap pulse |

## Verification
The assertions assume the control inputs are known after reset and that `trap_num` is meaningful only with `evt_kind`=0; they make no assumption about how often events, returns and writes collide. The stimulus first drives directed single-source cycles, then deliberate collisions of trap, return, move-to and debug writes, then a long run where every input is drawn at random each cycle, so all priority orders and the PC wrap at 0xFFFF occur while every input stays at a legal, defined value.

// File: rtl/crf_pkg.sv
package crf_pkg;

    localparam int CR_W     = 16;
    localparam int CR_IDX_W = 4;

    localparam logic [3:0] CR_STAT   = 4'd0;
    localparam logic [3:0] CR_BSTAT  = 4'd1;
    localparam logic [3:0] CR_PC     = 4'd2;
    localparam logic [3:0] CR_BPC    = 4'd3;
    localparam logic [3:0] CR_RCNT   = 4'd7;
    localparam logic [3:0] CR_RSTART = 4'd8;
    localparam logic [3:0] CR_REND   = 4'd9;
    localparam logic [3:0] CR_MODS   = 4'd10;
    localparam logic [3:0] CR_MODE   = 4'd11;
    localparam logic [3:0] CR_BRK    = 4'd14;

    localparam logic [15:0] STAT_RSVD  = 16'h4032;
    localparam logic [15:0] STAT_KEEP  = 16'h8000;
    localparam logic [15:0] VEC_TRAP0  = 16'hFFC4;
    localparam logic [15:0] VEC_RSVD   = 16'hFFC2;
    localparam logic [15:0] VEC_ADDR   = 16'hFFC3;
    localparam logic [15:0] VEC_DBG    = 16'hFFD5;
    localparam logic [3:0]  TRAP_SYSCALL = 4'd15;

    typedef enum logic [1:0] {
        EVK_TRAP      = 2'd0,
        EVK_RSVD_INSN = 2'd1,
        EVK_ADDR_ERR  = 2'd2,
        EVK_DBG_TRAP  = 2'd3
    } evt_kind_e;

    typedef struct packed {
        logic sup;   // 15
        logic ea;    // 13
        logic db;    // 12
        logic dm;    // 11
        logic ie;    // 10
        logic rp;    // 9
        logic md;    // 8
        logic xm;    // 7 extended mode
        logic ss;    // 6 stack select
        logic fa;    // 3
        logic fb;    // 2
        logic cy;    // 0
    } stat_flags_t;

    function automatic stat_flags_t stat_unpack(logic [15:0] w);
        stat_flags_t f;
        f.sup = w[15];
        f.ea  = w[13];
        f.db  = w[12];
        f.dm  = w[11];
        f.ie  = w[10];
        f.rp  = w[9];
        f.md  = w[8];
        f.xm  = w[7];
        f.ss  = w[6];
        f.fa  = w[3];
        f.fb  = w[2];
        f.cy  = w[0];
        return f;
    endfunction

    function automatic logic [15:0] stat_pack(stat_flags_t f);
        logic [15:0] w;
        w     = '0;
        w[15] = f.sup;
        w[13] = f.ea;
        w[12] = f.db;
        w[11] = f.dm;
        w[10] = f.ie;
        w[9]  = f.rp;
        w[8]  = f.md;
        w[7]  = f.xm;
        w[6]  = f.ss;
        w[3]  = f.fa;
        w[2]  = f.fb;
        w[0]  = f.cy;
        return w;
    endfunction

    function automatic logic [15:0] cr_store(logic [3:0] idx, logic [15:0] v);
        logic [15:0] r;
        case (idx)
            CR_STAT, CR_BSTAT: r = v & ~STAT_RSVD;
            CR_MODS, CR_MODE:  r = v & 16'hFFFE;
            default:           r = v;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/crf_status.sv
module crf_status
    import crf_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        wr_en,
    input  logic [15:0] wr_val,
    input  logic        trap_clr,
    output logic [15:0] stat_word,
    output logic        ill
);
    stat_flags_t flags_q;
    stat_flags_t wr_flags;
    logic        ill_q;

    assign wr_flags = stat_unpack(wr_val);

    always_ff @(posedge clk) begin
        if (rst) begin
            flags_q <= '0;
            ill_q   <= 1'b0;
        end else begin
            ill_q <= 1'b0;
            if (trap_clr) begin
                flags_q     <= '0;
                flags_q.sup <= flags_q.sup;
            end else if (wr_en) begin
                flags_q <= wr_flags;
                ill_q   <= wr_flags.ss && !wr_flags.xm;
            end
        end
    end

    assign stat_word = stat_pack(flags_q);
    assign ill       = ill_q;

    AST_TRAP_KEEPS_SUP: assert property (@(posedge clk) disable iff (rst)
        trap_clr |=> stat_word == ($past(stat_word) & STAT_KEEP)); // R6
    AST_ILL_FROM_WRITE: assert property (@(posedge clk) disable iff (rst)
        ill |-> ($past(wr_en) && !$past(trap_clr))); // R5
    AST_ILL_STORED: assert property (@(posedge clk) disable iff (rst)
        ill |-> (stat_word[6] && !stat_word[7])); // R5
endmodule

// File: rtl/crf_vector.sv
module crf_vector
    import crf_pkg::*;
(
    input  logic        evt_req,
    input  logic [1:0]  evt_kind,
    input  logic [3:0]  trap_num,
    output logic        take,
    output logic        syscall,
    output logic [15:0] vec
);
    evt_kind_e kind;
    assign kind = evt_kind_e'(evt_kind);

    always_comb begin
        syscall = evt_req && (kind == EVK_TRAP) && (trap_num == TRAP_SYSCALL);
        take    = evt_req && !syscall;
        case (kind)
            EVK_RSVD_INSN: vec = VEC_RSVD;
            EVK_ADDR_ERR:  vec = VEC_ADDR;
            EVK_DBG_TRAP:  vec = VEC_DBG;
            default:       vec = VEC_TRAP0 + {12'd0, trap_num};
        endcase
    end
endmodule

// File: rtl/crf_bank.sv
module crf_bank
    import crf_pkg::*;
#(
    parameter int W     = CR_W,
    parameter int IDX_W = CR_IDX_W,
    localparam int NREG = 1 << IDX_W
)(
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     wr_en,
    input  logic [IDX_W-1:0]         wr_idx,
    input  logic [W-1:0]             wr_val,
    input  logic                     pc_ld,
    input  logic [W-1:0]             pc_val,
    input  logic                     bpc_ld,
    input  logic [W-1:0]             bpc_val,
    input  logic                     bstat_ld,
    input  logic [W-1:0]             bstat_val,
    output logic [NREG-1:0][W-1:0]   regs_o
);
    assign regs_o[0] = '0;

    for (genvar i = 1; i < NREG; i++) begin : g_reg
        localparam logic [IDX_W-1:0] MY = IDX_W'(i);
        logic [W-1:0] q;
        always_ff @(posedge clk) begin
            if (rst)
                q <= '0;
            else if (MY == CR_PC && pc_ld)
                q <= pc_val;
            else if (MY == CR_BPC && bpc_ld)
                q <= bpc_val;
            else if (MY == CR_BSTAT && bstat_ld)
                q <= cr_store(MY, bstat_val);
            else if (wr_en && wr_idx == MY)
                q <= cr_store(MY, wr_val);
        end
        assign regs_o[i] = q;
    end

    AST_MOD_LSB_ZERO: assert property (@(posedge clk) disable iff (rst)
        !regs_o[CR_MODS][0] && !regs_o[CR_MODE][0]); // R4
    AST_BSTAT_RSVD_ZERO: assert property (@(posedge clk) disable iff (rst)
        (regs_o[CR_BSTAT] & STAT_RSVD) == '0); // R3
endmodule

// File: rtl/cpu_ctrl_regs.sv
module cpu_ctrl_regs
    import crf_pkg::*;
#(
    parameter int DATA_W = CR_W,
    parameter int IDX_W  = CR_IDX_W,
    localparam int NREG  = 1 << IDX_W
)(
    input  logic              clk,
    input  logic              rst,
    input  logic              mt_en,
    input  logic [IDX_W-1:0]  mt_idx,
    input  logic [DATA_W-1:0] mt_data,
    input  logic [IDX_W-1:0]  mf_idx,
    output logic [DATA_W-1:0] mf_data,
    input  logic              dbg_wr,
    input  logic [IDX_W-1:0]  dbg_idx,
    input  logic [DATA_W-1:0] dbg_wdata,
    output logic [DATA_W-1:0] dbg_rdata,
    input  logic              evt_req,
    input  logic [1:0]        evt_kind,
    input  logic [3:0]        trap_num,
    input  logic              rte_req,
    output logic [DATA_W-1:0] pc_o,
    output logic [DATA_W-1:0] psw_o,
    output logic              ill_o,
    output logic              syscall_o
);
    logic                       take, sys_now;
    logic [DATA_W-1:0]          vec;
    logic                       any_wr, gen_wr, st_wr, rte_go;
    logic [IDX_W-1:0]           wr_idx;
    logic [DATA_W-1:0]          wr_val, st_val, stat_word;
    logic [NREG-1:0][DATA_W-1:0] regs;
    logic                       sys_q;

    crf_vector u_vec (
        .evt_req (evt_req),
        .evt_kind(evt_kind),
        .trap_num(trap_num),
        .take    (take),
        .syscall (sys_now),
        .vec     (vec)
    );

    // move-to port wins over the debug port
    assign any_wr = mt_en || dbg_wr;
    assign wr_idx = mt_en ? mt_idx  : dbg_idx;
    assign wr_val = mt_en ? mt_data : dbg_wdata;

    // event > return > writes
    assign rte_go = rte_req && !evt_req;
    assign gen_wr = any_wr && !evt_req && !rte_req;
    assign st_wr  = rte_go || (gen_wr && wr_idx == CR_STAT);
    assign st_val = rte_go ? regs[CR_BSTAT] : wr_val;

    crf_status u_stat (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (st_wr),
        .wr_val   (st_val),
        .trap_clr (take),
        .stat_word(stat_word),
        .ill      (ill_o)
    );

    crf_bank #(.W(DATA_W), .IDX_W(IDX_W)) u_bank (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (gen_wr && wr_idx != CR_STAT),
        .wr_idx   (wr_idx),
        .wr_val   (wr_val),
        .pc_ld    (take || rte_go),
        .pc_val   (take ? vec : regs[CR_BPC]),
        .bpc_ld   (take),
        .bpc_val  (regs[CR_PC] + DATA_W'(1)),
        .bstat_ld (take),
        .bstat_val(stat_word),
        .regs_o   (regs)
    );

    always_ff @(posedge clk) begin
        if (rst) sys_q <= 1'b0;
        else     sys_q <= sys_now;
    end

    assign syscall_o = sys_q;
    assign pc_o      = regs[CR_PC];
    assign psw_o     = stat_word;
    assign mf_data   = (mf_idx  == CR_STAT) ? stat_word : regs[mf_idx];
    assign dbg_rdata = (dbg_idx == CR_STAT) ? stat_word : regs[dbg_idx];

    AST_VECTOR_PC: assert property (@(posedge clk) disable iff (rst)
        take |=> pc_o == $past(vec)); // R6
    AST_VECTOR_BPC: assert property (@(posedge clk) disable iff (rst)
        take |=> regs[CR_BPC] == $past(pc_o) + DATA_W'(1)); // R6
    AST_RETURN_PC: assert property (@(posedge clk) disable iff (rst)
        (rte_req && !evt_req) |=> pc_o == $past(regs[CR_BPC])); // R9
    AST_SYSCALL_HOLDS: assert property (@(posedge clk) disable iff (rst)
        sys_now |=> ($stable(pc_o) && $stable(psw_o) && $stable(regs[CR_BSTAT]))); // R7
    AST_SYSCALL_SRC: assert property (@(posedge clk) disable iff (rst)
        syscall_o |-> $past(evt_req && evt_kind == 2'd0 && trap_num == 4'd15)); // R7
endmodule

// File: tb/cpu_ctrl_regs_tb.sv
module cpu_ctrl_regs_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        mt_en = 0, dbg_wr = 0, evt_req = 0, rte_req = 0;
    logic [3:0]  mt_idx = 0, mf_idx = 0, dbg_idx = 0, trap_num = 0;
    logic [15:0] mt_data = 0, dbg_wdata = 0;
    logic [1:0]  evt_kind = 0;
    logic [15:0] mf_data, dbg_rdata, pc_o, psw_o;
    logic        ill_o, syscall_o;

    always #10 clk = ~clk; // 50 MHz

    cpu_ctrl_regs dut_i (
        .clk(clk), .rst(rst),
        .mt_en(mt_en), .mt_idx(mt_idx), .mt_data(mt_data),
        .mf_idx(mf_idx), .mf_data(mf_data),
        .dbg_wr(dbg_wr), .dbg_idx(dbg_idx), .dbg_wdata(dbg_wdata), .dbg_rdata(dbg_rdata),
        .evt_req(evt_req), .evt_kind(evt_kind), .trap_num(trap_num), .rte_req(rte_req),
        .pc_o(pc_o), .psw_o(psw_o), .ill_o(ill_o), .syscall_o(syscall_o)
    );

    int    errors = 0;
    int    checks = 0;
    string cur_req = "R1";

    // behavioural reference state
    int unsigned m_reg [16];
    int unsigned m_psw;
    bit          m_ill, m_sys;

    function automatic int unsigned store_val(int unsigned idx, int unsigned v);
        if (idx <= 1)              return v & 32'hBFCD;
        if (idx == 10 || idx == 11) return v & 32'hFFFE;
        return v & 32'hFFFF;
    endfunction

    function automatic void psw_put(int unsigned v);
        m_psw = v & 32'hBFCD;
        m_ill = ((v >> 6) & 1) == 1 && ((v >> 7) & 1) == 0;
    endfunction

    function automatic void model_step();
        int unsigned vec;
        m_ill = 0;
        m_sys = 0;
        if (rst) begin
            foreach (m_reg[k]) m_reg[k] = 0;
            m_psw = 0;
        end else if (evt_req) begin
            if (evt_kind == 0 && trap_num == 15) m_sys = 1;
            else begin
                case (evt_kind)
                    2'd1: vec = 32'hFFC2;
                    2'd2: vec = 32'hFFC3;
                    2'd3: vec = 32'hFFD5;
                    default: vec = 32'hFFC4 + trap_num;
                endcase
                m_reg[3] = (m_reg[2] + 1) & 32'hFFFF;
                m_reg[1] = m_psw;
                m_psw    = m_psw & 32'h8000;
                m_reg[2] = vec;
            end
        end else if (rte_req) begin
            m_reg[2] = m_reg[3];
            psw_put(m_reg[1]);
        end else if (mt_en || dbg_wr) begin
            int unsigned i, d;
            i = mt_en ? mt_idx : dbg_idx;
            d = mt_en ? mt_data : dbg_wdata;
            if (i == 0) psw_put(d);
            else m_reg[i] = store_val(i, d);
        end
    endfunction

    function automatic int unsigned rd(int unsigned i);
        return (i == 0) ? m_psw : m_reg[i];
    endfunction

    task automatic chk(string what, int unsigned got, int unsigned exp);
        checks++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s %s: got %h expected %h", cur_req, what, got, exp);
        end
    endtask

    task automatic cyc();
        @(posedge clk);
        model_step();
        @(negedge clk);
        chk("pc_o", pc_o, m_reg[2]);
        chk("psw_o", psw_o, m_psw);
        chk("mf_data", mf_data, rd(mf_idx));
        chk("dbg_rdata", dbg_rdata, rd(dbg_idx));
        chk("ill_o", ill_o, m_ill);
        chk("syscall_o", syscall_o, m_sys);
    endtask

    task automatic idle();
        mt_en = 0; dbg_wr = 0; evt_req = 0; rte_req = 0;
    endtask

    task automatic mt(int unsigned i, int unsigned d);
        idle(); mt_en = 1; mt_idx = 4'(i); mt_data = 16'(d); mf_idx = 4'(i);
        cyc();
        idle(); cyc();
    endtask

    task automatic dbg(int unsigned i, int unsigned d);
        idle(); dbg_wr = 1; dbg_idx = 4'(i); dbg_wdata = 16'(d);
        cyc();
        idle(); cyc();
    endtask

    task automatic evt(int unsigned k, int unsigned n);
        idle(); evt_req = 1; evt_kind = 2'(k); trap_num = 4'(n);
        cyc();
        idle(); cyc();
    endtask

    task automatic rte();
        idle(); rte_req = 1;
        cyc();
        idle(); cyc();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        // R1: reset state
        cur_req = "R1";
        cyc(); cyc();
        @(negedge clk); rst = 0;
        for (int i = 0; i < 16; i++) begin
            mf_idx = 4'(i); dbg_idx = 4'(15 - i); cyc();
        end

        // R2: index map, plain storage, packed status read
        cur_req = "R2";
        for (int i = 2; i < 16; i++) begin
            if (i != 10 && i != 11) mt(i, 16'hA5A5 ^ (i * 16'h1111));
        end
        for (int i = 0; i < 16; i++) begin
            mf_idx = 4'(i); cyc();
        end
        mt(0, 16'h0081);

        // R3: reserved status bits dropped on both copies
        cur_req = "R3";
        mt(0, 16'hFFFF);
        mt(1, 16'hFFFF);
        mf_idx = 1; cyc();

        // R4: modulo bounds drop bit 0
        cur_req = "R4";
        mt(10, 16'h1235);
        mt(11, 16'hFFFF);
        mt(9, 16'h1235);
        mf_idx = 11; cyc();

        // R5: stack select without extended mode
        cur_req = "R5";
        mt(0, 16'h0040);
        mt(0, 16'h00C0);
        dbg(0, 16'h8040);

        // R10: debug port paths and write collision
        cur_req = "R10";
        dbg(8, 16'hBEEF);
        dbg(10, 16'h0003);
        idle(); mt_en = 1; mt_idx = 7; mt_data = 16'h1111;
        dbg_wr = 1; dbg_idx = 7; dbg_wdata = 16'h2222; mf_idx = 7;
        cyc(); idle(); cyc();

        // R6: every table trap
        cur_req = "R6";
        for (int n = 0; n < 15; n++) begin
            mt(0, (16'h9F8D ^ (n << 9)) & 16'hFFBF);
            mt(2, 16'h0100 + n);
            mf_idx = 1; dbg_idx = 3;
            evt(0, n);
        end
        mt(2, 16'hFFFF);
        evt(0, 3);

        // R7: system-call trap, with a colliding write
        cur_req = "R7";
        mt(0, 16'h0085);
        idle(); evt_req = 1; evt_kind = 0; trap_num = 15;
        mt_en = 1; mt_idx = 2; mt_data = 16'h5555;
        cyc(); idle(); cyc();

        // R8: fixed exception vectors, trap_num ignored
        cur_req = "R8";
        for (int k = 1; k < 4; k++) begin
            mt(0, 16'h8C01 | k);
            evt(k, 15);
        end

        // R9: return restores, including the illegal check
        cur_req = "R9";
        mt(0, 16'h0F81);
        evt(0, 9);
        rte();
        mt(1, 16'h0040);
        mt(3, 16'h4321);
        rte();

        // R11: collisions
        cur_req = "R11";
        idle(); evt_req = 1; evt_kind = 2; rte_req = 1;
        mt_en = 1; mt_idx = 8; mt_data = 16'h7777; mf_idx = 8;
        cyc(); idle(); cyc();
        idle(); rte_req = 1; dbg_wr = 1; dbg_idx = 9; dbg_wdata = 16'h3333; dbg_idx = 9;
        cyc(); idle(); cyc();
        for (int c = 0; c < 400; c++) begin
            mt_en     = ($urandom % 3) == 0;
            dbg_wr    = ($urandom % 4) == 0;
            evt_req   = ($urandom % 6) == 0;
            rte_req   = ($urandom % 6) == 0;
            mt_idx    = 4'($urandom);
            dbg_idx   = 4'($urandom);
            mf_idx    = 4'($urandom);
            mt_data   = 16'($urandom);
            dbg_wdata = 16'($urandom);
            evt_kind  = 2'($urandom);
            trap_num  = 4'($urandom);
            cyc();
        end
        idle(); cyc();

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule